// File: doc/BRIEF.md
# Glitch-Free Clock Source Selector

This block picks the clock that drives a processor's clock pin. One source is a fast, free-running master clock. The other is a slow clock that software steps by hand, and it is held low whenever a change of source is pending. A select request can come from any clock domain and at any moment. The block moves it through a synchronizer chain clocked on the falling edge of the master clock. The mux control therefore changes only at the start of a master cycle, while the master clock is low. Because the slow clock is low at that moment too, the output never shows a runt high or low phase.

The block also exports the selection currently in force. Software can poll it to confirm that a switch has completed before it starts stepping the slow clock. The number of synchronizer stages and the gate structure of the output mux are both parameters.

Top module: `clk_source_sel`

## Requirements
- R1: While the applied selection is 0, `cpu_clk` follows `clk_master`.
- R2: While the applied selection is 1, `cpu_clk` follows `clk_slow`, and toggling of `clk_master` has no effect on it.
- R3: `sel_applied` changes outside reset only at a falling edge of `clk_master`, so every switch begins while the master clock is low.
- R4: With the default two stages, a request level that is present at two consecutive master falling edges becomes `sel_applied` at the second of them and not at the first.
- R5: No high or low phase of `cpu_clk` is shorter than the shorter phase of the two sources. This holds whatever the phase of the request relative to `clk_master`, provided `clk_slow` is low when the switch takes effect.
- R6: An active-low `rst_n` forces `sel_applied` to 0 (master clock) at once. The selection stays 0 for as long as reset is held, whatever the request.
- R7: A request pulse that is not present at any falling edge of `clk_master` has no effect on `sel_applied` or on `cpu_clk`.
- R8: `sel_applied` reports the source actually driving `cpu_clk`: 0 for the master clock, 1 for the slow clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_master | input | 1 | Fast free-running master clock; its falling edge retimes the selection |
| clk_slow | input | 1 | Software-stepped slow clock, low around any switch |
| sel_req | input | 1 | Asynchronous source request: 0 master, 1 slow |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_clk | output | 1 | Selected clock for the processor |
| sel_applied | output | 1 | Selection currently in force: 0 master, 1 slow |

## Verification
The assertions assume two things about the inputs. First, `clk_slow` is low whenever the applied selection changes. Second, `clk_slow` does not fall while it is not selected unless its value is of no concern. The stimulus respects both. The slow clock is parked low before every request and during reset, and it is toggled only while the slow source is selected. Requests are placed just after a master rising edge, just before a master falling edge and during the low phase, so the retiming is exercised from each side. Throughout, a monitor measures every phase width of `cpu_clk`.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

   typedef enum logic {
      SRC_MASTER = 1'b0,
      SRC_SLOW   = 1'b1
   } clk_src_e;

   localparam int unsigned MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/clksel_sync.sv
module clksel_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   import clksel_pkg::*;

   localparam int unsigned LAST = STAGES - 1;

   generate
      if (STAGES < MIN_SYNC_STAGES) begin : g_bad_depth
         $error("clksel_sync: STAGES must be at least %0d", MIN_SYNC_STAGES);
      end
   endgenerate

   logic [STAGES-1:0] stg;

   // Every stage samples on the falling edge of the master clock.
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[LAST];

   genvar gi;
   generate
      for (gi = 0; gi < STAGES - 1; gi++) begin : g_shift_chk
         AST_SYNC_SHIFT: assert property (@(negedge clk) disable iff (!rst_n)
            1'b1 |=> (stg[gi+1] == $past(stg[gi])))
            else $error("sync stage %0d did not advance", gi); // R4
      end
   endgenerate

endmodule

// File: rtl/clksel_mux.sv
module clksel_mux #(
   parameter bit AND_OR = 1'b1
) (
   input  logic                  clk_a,
   input  logic                  clk_b,
   input  clksel_pkg::clk_src_e  sel,
   output logic                  clk_o
);
   import clksel_pkg::*;

   logic pick_b;
   assign pick_b = (sel == SRC_SLOW);

   generate
      if (AND_OR) begin : g_and_or
         logic path_a;
         logic path_b;
         assign path_a = clk_a & ~pick_b;
         assign path_b = clk_b &  pick_b;
         assign clk_o  = path_a | path_b;
      end else begin : g_ternary
         assign clk_o = pick_b ? clk_b : clk_a;
      end
   endgenerate

endmodule

// File: rtl/clk_source_sel.sv
module clk_source_sel #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          MUX_AND_OR  = 1'b1
) (
   input  logic clk_master,
   input  logic clk_slow,
   input  logic sel_req,
   input  logic rst_n,
   output logic cpu_clk,
   output logic sel_applied
);
   import clksel_pkg::*;

   generate
      if (SYNC_STAGES < MIN_SYNC_STAGES) begin : g_bad_cfg
         $error("clk_source_sel: SYNC_STAGES below %0d", MIN_SYNC_STAGES);
      end
   endgenerate

   logic     sel_sync;
   clk_src_e src_now;

   clksel_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk_master),
      .rst_n (rst_n),
      .d     (sel_req),
      .q     (sel_sync)
   );

   assign src_now     = clk_src_e'(sel_sync);
   assign sel_applied = sel_sync;

   clksel_mux #(.AND_OR(MUX_AND_OR)) u_mux (
      .clk_a (clk_master),
      .clk_b (clk_slow),
      .sel   (src_now),
      .clk_o (cpu_clk)
   );

   // A change of source must land while both clocks sit low.
   always @(sel_applied) begin
      if (rst_n) begin
         AST_SWITCH_MASTER_LOW: assert (clk_master == 1'b0)
            else $error("selection changed with master clock high"); // R3
         AST_SWITCH_SLOW_LOW: assert (clk_slow == 1'b0)
            else $error("selection changed with slow clock high"); // R5
      end
   end

   AST_MASTER_PATH: assert property (@(negedge clk_master) disable iff (!rst_n)
      (sel_applied == 1'b0) |-> cpu_clk)
      else $error("master high phase missing on output"); // R1

   AST_SLOW_PATH: assert property (@(negedge clk_slow) disable iff (!rst_n)
      (sel_applied == 1'b1) |-> cpu_clk)
      else $error("slow high phase missing on output"); // R2

endmodule

// File: tb/test_clk_source_sel.sv
module test_clk_source_sel;

   logic clk_master = 1'b0;
   logic clk_slow   = 1'b0;
   logic sel_req    = 1'b0;
   logic rst_n      = 1'b0;
   logic cpu_clk;
   logic sel_applied;

   int n_checks = 0;
   int n_fail   = 0;

   localparam realtime HALF = 10.0;   // 50 MHz master clock

   always #(HALF) clk_master = ~clk_master;

   clk_source_sel i_clk_source_sel (
      .clk_master  (clk_master),
      .clk_slow    (clk_slow),
      .sel_req     (sel_req),
      .rst_n       (rst_n),
      .cpu_clk     (cpu_clk),
      .sel_applied (sel_applied)
   );

   task automatic check(input string req, input string what,
                        input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
      end
   endtask

   // R5: every phase of the output must be at least one master half period.
   bit      mon_en = 1'b0;
   realtime last_edge = 0.0;
   always @(cpu_clk) begin
      if (mon_en) begin
         n_checks++;
         if ($realtime - last_edge < HALF - 0.001) begin
            n_fail++;
            $display("FAIL R5 phase width: actual %0t expected >= %0t",
                     $realtime - last_edge, HALF);
         end
      end
      last_edge = $realtime;
   end

   // R3: outside reset the selection may only move while the master clock is low.
   always @(sel_applied) begin
      if (rst_n) begin
         n_checks++;
         if (clk_master !== 1'b0) begin
            n_fail++;
            $display("FAIL R3 switch edge: actual master %b expected 0", clk_master);
         end
      end
   end

   task automatic start_monitor();
      @(posedge clk_master);
      #5;
      last_edge = $realtime - 5.0;
      mon_en    = 1'b1;
   endtask

   task automatic expect_master(input string req);
      @(posedge clk_master); #2;
      check(req, "output high with master", cpu_clk, 1'b1);
      @(negedge clk_master); #2;
      check(req, "output low with master", cpu_clk, 1'b0);
   endtask

   task automatic t_reset_state();
      repeat (3) @(negedge clk_master);
      #1;
      check("R6", "selection in reset", sel_applied, 1'b0);
      expect_master("R6");
      @(negedge clk_master); #3;
      rst_n = 1'b1;
      expect_master("R1");
      check("R8", "selection reports master", sel_applied, 1'b0);
   endtask

   // Request raised at a chosen phase; align_fall picks a falling or rising reference edge.
   task automatic switch_req(input logic level, input bit align_fall, input realtime offs);
      if (align_fall) @(negedge clk_master);
      else            @(posedge clk_master);
      #(offs);
      sel_req = level;
      @(negedge clk_master); #1;
      check("R4", "not applied after first falling edge", sel_applied, ~level);
      @(negedge clk_master); #1;
      check("R4", "applied at second falling edge", sel_applied, level);
      check("R3", "output low right after switch", cpu_clk, 1'b0);
   endtask

   task automatic run_slow();
      for (int k = 0; k < 3; k++) begin
         #50; clk_slow = 1'b1;
         #1;  check("R2", "output follows slow high", cpu_clk, 1'b1);
         check("R8", "selection reports slow", sel_applied, 1'b1);
         #49; clk_slow = 1'b0;
         #1;  check("R2", "output follows slow low", cpu_clk, 1'b0);
      end
   endtask

   task automatic t_switch_cycle(input bit align_fall, input realtime offs);
      switch_req(1'b1, align_fall, offs);
      run_slow();
      switch_req(1'b0, align_fall, offs);
      expect_master("R1");
      check("R8", "selection reports master", sel_applied, 1'b0);
   endtask

   task automatic t_short_pulse();
      @(negedge clk_master); #2;
      sel_req = 1'b1;
      #15;
      sel_req = 1'b0;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk_master); #1;
         check("R7", "short request ignored", sel_applied, 1'b0);
      end
      expect_master("R7");
   endtask

   task automatic t_reset_in_slow();
      switch_req(1'b1, 1'b0, 4.0);
      mon_en = 1'b0;
      @(negedge clk_master); #5;
      rst_n = 1'b0;
      #1;
      check("R6", "reset forces master at once", sel_applied, 1'b0);
      for (int k = 0; k < 2; k++) begin
         @(negedge clk_master); #1;
         check("R6", "held in reset despite request", sel_applied, 1'b0);
      end
      expect_master("R6");
      sel_req = 1'b0;
      @(negedge clk_master); #3;
      rst_n = 1'b1;
      expect_master("R1");
   endtask

   bit done = 1'b0;

   initial begin
      t_reset_state();
      start_monitor();
      t_switch_cycle(1'b0, 1.0);   // just after a rising edge
      t_switch_cycle(1'b0, 9.0);   // just before a falling edge
      t_switch_cycle(1'b1, 3.0);   // during the low phase
      t_short_pulse();
      t_reset_in_slow();
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            #200000;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule